// File: doc/BRIEF.md
# Snooping MESI Coherence Controller for a Shared Word

This block keeps N private single-line caches coherent for one shared memory word. The caches sit on a common snooping bus, and each line carries a MESI state and a data value. A single backing memory word sits behind them. Each clock the controller accepts at most one request, qualified by a valid strobe. A request carries an operation (read, write or evict), a processor index and a write value. In that same edge the controller updates the state and data of every line and the memory word.

One cycle after an accepted request, the block returns a response. The response holds the requester's line data after the operation, a hit flag, and flags telling whether the operation needed a memory read or a memory write-back on the bus. On a read miss, data comes from a peer cache whenever one holds a valid copy. The peer is searched in fixed priority from the lowest processor index. Memory is written only when a dirty owner is snooped by a read or a Modified line is evicted. Invalidated lines have their data cleared to zero. All states and data are visible on output ports.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: Under reset every line is Invalid (state code 0) with data 0, the memory word holds 15213, and resp_valid is 0.
- R2: A read to a line in Modified, Exclusive or Shared state returns that line's data with resp_hit 1, both bus flags 0, and no state, data or memory change anywhere.
- R3: A read miss while another cache holds the line Shared or Exclusive makes the requester Shared with that peer's data. An Exclusive peer drops to Shared. Memory is untouched and both bus flags are 0.
- R4: A read miss while another cache holds the line Modified copies the owner's data into memory, drops the owner to Shared, makes the requester Shared with the same data, and raises resp_bus_wr.
- R5: A read miss with no valid copy elsewhere loads the memory word and makes the requester Exclusive. It raises resp_bus_rd, and resp_hit is 0.
- R6: A write to a line in Modified or Exclusive state stores the write value, ends in Modified, raises no bus flag and leaves every other line unchanged.
- R7: A write to a Shared line, or a write miss while other valid copies exist, sets every other valid line to Invalid with data 0. The requester becomes Modified with the write value, and no bus flag is raised.
- R8: A write miss with no valid copy elsewhere raises resp_bus_rd (memory fetch with intent to modify). The requester ends Modified holding the write value, and memory is unchanged.
- R9: Evicting a Modified line copies its data to memory and raises resp_bus_wr. Evicting any line leaves it Invalid with data 0. Evicting a clean or Invalid line leaves memory unchanged and raises no bus flag. resp_hit tells whether the line was valid.
- R10: Operation codes are 0 read, 1 write, 2 evict; code 3 is ignored (no response, no change). resp_valid is high exactly one cycle after an accepted request, and resp_rdata is the requester's line data after the operation. The state of cache j sits in line_state bits [2j+1:2j] (I=0, S=1, E=2, M=3), and its data sits in line_data bits [DW*j+DW-1:DW*j].
- R11: At all times at most one line is Exclusive or Modified, and no such line coexists with a Shared line. Every valid line holds the most recently written value (15213 before any write), and every Invalid line holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 evict, 3 ignored |
| req_cpu | input | IDXW | Requesting processor index |
| req_wdata | input | DW | Value for a write |
| resp_valid | output | 1 | Response strobe, one cycle after an accepted request |
| resp_rdata | output | DW | Requester's line data after the operation |
| resp_hit | output | 1 | Requester's line was valid before the operation |
| resp_bus_rd | output | 1 | Operation fetched the memory word |
| resp_bus_wr | output | 1 | Operation wrote the memory word |
| mem_word | output | DW | Backing memory word |
| line_state | output | 2*N_CPU | Packed MESI state of all lines |
| line_data | output | N_CPU*DW | Packed data of all lines |

## Verification
The assertions assume that a write value only reaches a line through an accepted request, and that req_cpu and req_op are stable while req_valid is sampled. The invariant checks also assume that the invariants held in the previous cycle, which holds from reset onward. The stimulus drives each request for exactly one clock, sets it up half a cycle before the edge, and keeps the index below N_CPU. Reserved operation codes are mixed in to show that they leave every line and the memory word untouched.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [1:0] {
      LS_I = 2'd0,
      LS_S = 2'd1,
      LS_E = 2'd2,
      LS_M = 2'd3
   } lstate_t;

   typedef enum logic [1:0] {
      OP_RD  = 2'd0,
      OP_WR  = 2'd1,
      OP_EV  = 2'd2,
      OP_NOP = 2'd3
   } op_t;
endpackage

// File: rtl/coh_peer_pick.sv
// Finds the lowest-index valid line other than the requester.
module coh_peer_pick
   import coh_pkg::*;
#(
   parameter int N_CPU = 4,
   parameter int DW    = 16,
   parameter int IDXW  = 2
) (
   input  logic [2*N_CPU-1:0]  st_flat,
   input  logic [N_CPU*DW-1:0] dat_flat,
   input  logic [IDXW-1:0]     req_cpu,
   output logic                found,
   output lstate_t             peer_st,
   output logic [DW-1:0]       peer_dat
);
   logic [N_CPU-1:0] vmask;
   logic [IDXW-1:0]  idx;

   for (genvar j = 0; j < N_CPU; j++) begin : g_mask
      assign vmask[j] = (st_flat[2*j +: 2] != LS_I) && (req_cpu != IDXW'(j));
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = N_CPU - 1; k >= 0; k--) begin
         if (vmask[k]) begin
            found = 1'b1;
            idx   = IDXW'(k);
         end
      end
   end

   assign peer_st  = lstate_t'(st_flat[2*int'(idx) +: 2]);
   assign peer_dat = dat_flat[DW*int'(idx) +: DW];
endmodule

// File: rtl/coh_line_next.sv
// Next state and data of one cache line for the current request.
module coh_line_next
   import coh_pkg::*;
#(
   parameter int DW      = 16,
   parameter int IDXW    = 2,
   parameter int LINE_ID = 0
) (
   input  logic            fire,
   input  op_t             op,
   input  logic [IDXW-1:0] req_cpu,
   input  logic            req_miss,
   input  logic            peer_found,
   input  logic [DW-1:0]   peer_dat,
   input  logic [DW-1:0]   mem_val,
   input  logic [DW-1:0]   wdata,
   input  lstate_t         cur_st,
   input  logic [DW-1:0]   cur_dat,
   output lstate_t         nxt_st,
   output logic [DW-1:0]   nxt_dat
);
   logic is_req;
   assign is_req = (req_cpu == IDXW'(LINE_ID));

   always_comb begin
      nxt_st  = cur_st;
      nxt_dat = cur_dat;
      if (fire) begin
         if (is_req) begin
            case (op)
               OP_RD: begin
                  if (cur_st == LS_I) begin
                     if (peer_found) begin
                        nxt_st  = LS_S;
                        nxt_dat = peer_dat;
                     end else begin
                        nxt_st  = LS_E;
                        nxt_dat = mem_val;
                     end
                  end
               end
               OP_WR: begin
                  // a miss fetches memory first; the write value overwrites it
                  nxt_st  = LS_M;
                  nxt_dat = wdata;
               end
               OP_EV: begin
                  nxt_st  = LS_I;
                  nxt_dat = '0;
               end
               default: ;
            endcase
         end else begin
            case (op)
               OP_RD: begin
                  if (req_miss && (cur_st == LS_E || cur_st == LS_M))
                     nxt_st = LS_S;
               end
               OP_WR: begin
                  if (cur_st != LS_I) begin
                     nxt_st  = LS_I;
                     nxt_dat = '0;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
   import coh_pkg::*;
#(
   parameter int          N_CPU    = 4,
   parameter int          DW       = 16,
   parameter int unsigned MEM_INIT = 15213,
   localparam int         IDXW     = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_op,
   input  logic [IDXW-1:0]     req_cpu,
   input  logic [DW-1:0]       req_wdata,
   output logic                resp_valid,
   output logic [DW-1:0]       resp_rdata,
   output logic                resp_hit,
   output logic                resp_bus_rd,
   output logic                resp_bus_wr,
   output logic [DW-1:0]       mem_word,
   output logic [2*N_CPU-1:0]  line_state,
   output logic [N_CPU*DW-1:0] line_data
);
   if (N_CPU < 2) begin : g_bad_n
      $error("coh_snoop_ctrl: N_CPU must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("coh_snoop_ctrl: DW must be positive");
   end

   localparam logic [DW-1:0] MEM_RST = DW'(MEM_INIT);

   logic [2*N_CPU-1:0]  st_q, st_d;
   logic [N_CPU*DW-1:0] dat_q, dat_d;
   logic [DW-1:0]       mem_q, mem_d;

   op_t           op;
   logic          cpu_ok, fire, req_miss;
   lstate_t       req_st;
   logic [DW-1:0] req_dat, req_dat_nxt;
   logic          peer_found;
   lstate_t       peer_st;
   logic [DW-1:0] peer_dat;

   assign op = op_t'(req_op);

   if ((1 << IDXW) == N_CPU) begin : g_idx_full
      assign cpu_ok = 1'b1;
   end else begin : g_idx_part
      assign cpu_ok = (req_cpu < IDXW'(N_CPU));
   end

   assign fire     = req_valid && (op != OP_NOP) && cpu_ok;
   assign req_st   = lstate_t'(st_q[2*int'(req_cpu) +: 2]);
   assign req_dat  = dat_q[DW*int'(req_cpu) +: DW];
   assign req_miss = (req_st == LS_I);

   coh_peer_pick #(.N_CPU(N_CPU), .DW(DW), .IDXW(IDXW)) u_pick (
      .st_flat  (st_q),
      .dat_flat (dat_q),
      .req_cpu  (req_cpu),
      .found    (peer_found),
      .peer_st  (peer_st),
      .peer_dat (peer_dat)
   );

   for (genvar j = 0; j < N_CPU; j++) begin : g_line
      lstate_t n_st;
      coh_line_next #(.DW(DW), .IDXW(IDXW), .LINE_ID(j)) u_line (
         .fire       (fire),
         .op         (op),
         .req_cpu    (req_cpu),
         .req_miss   (req_miss),
         .peer_found (peer_found),
         .peer_dat   (peer_dat),
         .mem_val    (mem_q),
         .wdata      (req_wdata),
         .cur_st     (lstate_t'(st_q[2*j +: 2])),
         .cur_dat    (dat_q[DW*j +: DW]),
         .nxt_st     (n_st),
         .nxt_dat    (dat_d[DW*j +: DW])
      );
      assign st_d[2*j +: 2] = n_st;
   end

   assign req_dat_nxt = dat_d[DW*int'(req_cpu) +: DW];

   logic snoop_wb, evict_wb, mem_fetch;
   assign snoop_wb  = fire && (op == OP_RD) && req_miss && peer_found && (peer_st == LS_M);
   assign evict_wb  = fire && (op == OP_EV) && (req_st == LS_M);
   assign mem_fetch = fire && (op == OP_RD || op == OP_WR) && req_miss && !peer_found;

   always_comb begin
      mem_d = mem_q;
      if (snoop_wb)      mem_d = peer_dat;
      else if (evict_wb) mem_d = req_dat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= '0;
         dat_q       <= '0;
         mem_q       <= MEM_RST;
         resp_valid  <= 1'b0;
         resp_rdata  <= '0;
         resp_hit    <= 1'b0;
         resp_bus_rd <= 1'b0;
         resp_bus_wr <= 1'b0;
      end else begin
         st_q        <= st_d;
         dat_q       <= dat_d;
         mem_q       <= mem_d;
         resp_valid  <= fire;
         resp_rdata  <= fire ? req_dat_nxt : '0;
         resp_hit    <= fire && !req_miss;
         resp_bus_rd <= mem_fetch;
         resp_bus_wr <= snoop_wb || evict_wb;
      end
   end

   assign mem_word   = mem_q;
   assign line_state = st_q;
   assign line_data  = dat_q;
endmodule

// File: rtl/coh_snoop_chk.sv
module coh_snoop_chk
   import coh_pkg::*;
#(
   parameter int          N_CPU    = 4,
   parameter int          DW       = 16,
   parameter int unsigned MEM_INIT = 15213,
   localparam int         IDXW     = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [1:0]          req_op,
   input logic [IDXW-1:0]     req_cpu,
   input logic [DW-1:0]       req_wdata,
   input logic                resp_valid,
   input logic                resp_hit,
   input logic                resp_bus_rd,
   input logic                resp_bus_wr,
   input logic [DW-1:0]       mem_word,
   input logic [2*N_CPU-1:0]  line_state,
   input logic [N_CPU*DW-1:0] line_data
);
   logic [N_CPU-1:0] em_mask, s_mask;
   logic             acc;
   logic [1:0]       rq_st;
   logic [DW-1:0]    shadow;

   for (genvar j = 0; j < N_CPU; j++) begin : g_m
      assign em_mask[j] = line_state[2*j+1];
      assign s_mask[j]  = (line_state[2*j +: 2] == LS_S);
   end

   assign acc   = req_valid && (req_op != 2'd3) && (int'(req_cpu) < N_CPU);
   assign rq_st = acc ? line_state[2*int'(req_cpu) +: 2] : 2'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          shadow <= DW'(MEM_INIT);
      else if (acc && req_op == 2'd1)      shadow <= req_wdata;
   end

   // R11
   one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(em_mask) <= 1);

   // R11
   owner_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((|em_mask) && (|s_mask)));

   for (genvar j = 0; j < N_CPU; j++) begin : g_a
      // R11
      copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (line_state[2*j +: 2] != 2'd0) |-> (line_data[DW*j +: DW] == shadow));
      // R11
      inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (line_state[2*j +: 2] == 2'd0) |-> (line_data[DW*j +: DW] == '0));
   end

   // R2
   rd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 2'd0 && rq_st != 2'd0) |=>
      (resp_hit && !resp_bus_rd && !resp_bus_wr && $stable(line_state)));

   // R9
   ev_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 2'd2 && rq_st == 2'd3) |=> resp_bus_wr);

   // R4
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_bus_wr |-> $stable(mem_word));

   // R10
   resp_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> resp_valid);

   // R10
   resp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !resp_valid);
endmodule

bind coh_snoop_ctrl coh_snoop_chk #(.N_CPU(N_CPU), .DW(DW), .MEM_INIT(MEM_INIT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_op      (req_op),
   .req_cpu     (req_cpu),
   .req_wdata   (req_wdata),
   .resp_valid  (resp_valid),
   .resp_hit    (resp_hit),
   .resp_bus_rd (resp_bus_rd),
   .resp_bus_wr (resp_bus_wr),
   .mem_word    (mem_word),
   .line_state  (line_state),
   .line_data   (line_data)
);

// File: tb/coh_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module coh_snoop_ctrl_tb;
   localparam int N  = 4;
   localparam int DW = 16;
   localparam int IW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [1:0]      req_op = '0;
   logic [IW-1:0]   req_cpu = '0;
   logic [DW-1:0]   req_wdata = '0;
   logic            resp_valid, resp_hit, resp_bus_rd, resp_bus_wr;
   logic [DW-1:0]   resp_rdata, mem_word;
   logic [2*N-1:0]  line_state;
   logic [N*DW-1:0] line_data;

   always #10 clk = ~clk;

   coh_snoop_ctrl #(.N_CPU(N), .DW(DW), .MEM_INIT(15213)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_cpu(req_cpu), .req_wdata(req_wdata), .resp_valid(resp_valid),
      .resp_rdata(resp_rdata), .resp_hit(resp_hit), .resp_bus_rd(resp_bus_rd),
      .resp_bus_wr(resp_bus_wr), .mem_word(mem_word), .line_state(line_state),
      .line_data(line_data)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   int            m_st [N];
   logic [DW-1:0] m_dat[N];
   logic [DW-1:0] m_mem;
   logic          e_valid, e_hit, e_brd, e_bwr;
   logic [DW-1:0] e_rdata;
   string         tag;

   task automatic chk(input bit ok, input string t, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
      end
   endtask

   function automatic logic [2*N-1:0] exp_state();
      logic [2*N-1:0] v;
      for (int j = 0; j < N; j++) v[2*j +: 2] = m_st[j][1:0];
      return v;
   endfunction

   function automatic logic [N*DW-1:0] exp_data();
      logic [N*DW-1:0] v;
      for (int j = 0; j < N; j++) v[DW*j +: DW] = m_dat[j];
      return v;
   endfunction

   // Reference model: I=0 S=1 E=2 M=3
   task automatic model(input int op, input int c, input logic [DW-1:0] wd);
      int pj;
      bit any;
      e_valid = 1'b0; e_hit = 1'b0; e_brd = 1'b0; e_bwr = 1'b0; e_rdata = '0;
      if (op == 3) begin
         tag = "R10";
         return;
      end
      e_valid = 1'b1;
      e_hit   = (m_st[c] != 0);
      pj = -1;
      for (int j = N - 1; j >= 0; j--) if (j != c && m_st[j] != 0) pj = j;
      any = (pj >= 0);
      if (op == 0) begin
         if (m_st[c] != 0) tag = "R2";
         else if (any) begin
            if (m_st[pj] == 3) begin
               m_mem = m_dat[pj]; e_bwr = 1'b1; tag = "R4";
            end else tag = "R3";
            m_st[pj] = 1; m_st[c] = 1; m_dat[c] = m_dat[pj];
         end else begin
            m_st[c] = 2; m_dat[c] = m_mem; e_brd = 1'b1; tag = "R5";
         end
      end else if (op == 1) begin
         if (m_st[c] >= 2) tag = "R6";
         else if (m_st[c] == 1 || any) tag = "R7";
         else begin tag = "R8"; e_brd = 1'b1; end
         for (int j = 0; j < N; j++) if (j != c) begin m_st[j] = 0; m_dat[j] = '0; end
         m_st[c] = 3; m_dat[c] = wd;
      end else begin
         tag = "R9";
         if (m_st[c] == 3) begin m_mem = m_dat[c]; e_bwr = 1'b1; end
         m_st[c] = 0; m_dat[c] = '0;
      end
      e_rdata = m_dat[c];
   endtask

   task automatic do_op(input int op, input int c, input logic [DW-1:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_op = op[1:0]; req_cpu = c[IW-1:0]; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      model(op, c, wd);
      chk(resp_valid == e_valid, tag, "resp_valid", 64'(resp_valid), 64'(e_valid));
      if (e_valid) begin
         chk(resp_rdata == e_rdata, tag, "resp_rdata", 64'(resp_rdata), 64'(e_rdata));
         chk(resp_hit == e_hit, tag, "resp_hit", 64'(resp_hit), 64'(e_hit));
         chk(resp_bus_rd == e_brd, tag, "resp_bus_rd", 64'(resp_bus_rd), 64'(e_brd));
         chk(resp_bus_wr == e_bwr, tag, "resp_bus_wr", 64'(resp_bus_wr), 64'(e_bwr));
      end
      chk(line_state == exp_state(), tag, "line_state", 64'(line_state), 64'(exp_state()));
      chk(line_data == exp_data(), tag, "line_data", 64'(line_data), 64'(exp_data()));
      chk(mem_word == m_mem, tag, "mem_word", 64'(mem_word), 64'(m_mem));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2021));
      for (int j = 0; j < N; j++) begin m_st[j] = 0; m_dat[j] = '0; end
      m_mem = 16'd15213;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(line_state == '0, "R1", "line_state", 64'(line_state), 64'd0);
      chk(line_data == '0, "R1", "line_data", 64'(line_data), 64'd0);
      chk(mem_word == 16'd15213, "R1", "mem_word", 64'(mem_word), 64'd15213);
      chk(resp_valid == 1'b0, "R1", "resp_valid", 64'(resp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corner cases
      do_op(0, 0, '0);        // R5 load from memory, Exclusive
      do_op(0, 1, '0);        // R3 Exclusive peer drops to Shared
      do_op(0, 2, '0);        // R3 Shared peer supplies
      do_op(0, 2, '0);        // R2 hit
      do_op(1, 2, 16'h1234);  // R7 write on Shared
      do_op(0, 0, '0);        // R4 dirty snoop write-back
      do_op(1, 3, 16'hBEEF);  // R7 write miss with peers
      do_op(1, 3, 16'h00AA);  // R6 write hit on Modified
      do_op(3, 1, 16'hFFFF);  // R10 reserved op ignored
      do_op(2, 3, '0);        // R9 evict Modified
      do_op(2, 3, '0);        // R9 evict Invalid
      do_op(0, 1, '0);        // R5 load written-back value
      do_op(1, 1, 16'h0F0F);  // R6 write hit on Exclusive
      do_op(2, 1, '0);        // R9 evict Modified
      do_op(1, 0, 16'h5555);  // R8 write miss, nobody holds it
      do_op(0, 0, '0);        // R2 read hit on Modified
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int r, op;
         r = int'($urandom_range(0, 19));
         op = (r < 8) ? 0 : (r < 14) ? 1 : (r < 19) ? 2 : 3;
         do_op(op, int'($urandom_range(0, N - 1)), 16'($urandom()));
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule